// File: doc/BRIEF.md
# Descriptor Table Register Unit

This block keeps the two system descriptor-table registers of a segmented processor. The global table register holds a 32-bit linear base, which is the address of the table's byte 0, and a 16-bit byte limit. The local table register holds a 16-bit selector together with a hidden cache: a 32-bit base, a 20-bit limit, 12 attribute bits and a valid flag. The hidden cache is driven continuously on output ports for the address-translation logic. Software can read it back only through the selector.

A command port carries four operations, encoded on `cmd_op`: `2'b00` load global, `2'b01` store global, `2'b10` load local selector and `2'b11` store local selector. When a local selector is loaded, its index is checked against the global limit. The unit then reads the 8-byte descriptor from the global table as two 32-bit words, through a valid/ready request channel and a response channel, and fills the hidden cache. A task-switch port writes the selector and the whole hidden cache in a single step.

The fetch sequencer has six states. `S_IDLE` goes to `S_ADDR_LO` when a fetch starts. `S_ADDR_LO` goes to `S_DATA_LO` when the request is accepted. `S_DATA_LO` goes to `S_ADDR_HI` when the first word arrives. `S_ADDR_HI` goes to `S_DATA_HI` when that request is accepted. `S_DATA_HI` goes to `S_COMMIT` when the second word arrives. `S_COMMIT` always returns to `S_IDLE`, and the hidden cache is written on that transition.

Top module: `dtr_unit`

## Requirements
- R1: After reset the global base is 0 and the global limit is 16'hFFFF. The local selector and local base are 0, the local limit is 20'h0FFFF, the attributes are 0, and `ldt_valid`, `busy`, `fault` and `st_valid` are all 0.
- R2: A load global (`cmd_op`=2'b00) writes `cmd_base` and `cmd_limit`. A store global (`cmd_op`=2'b01) raises `st_valid` for one cycle, one cycle after acceptance, and drives both values on `st_base` and `st_limit`, with `st_sel` set to 0.
- R3: A store local (`cmd_op`=2'b11) raises `st_valid` one cycle after acceptance and returns only the selector on `st_sel`. `st_base` and `st_limit` read 0.
- R4: A load local with a non-null selector that is within bounds reads the word at global base + index×8, where the index is `sel[15:3]`, and then the word at that address + 4. With w0 the first word and w1 the second, the unit commits base = {w1[31:24], w1[7:0], w0[31:16]}, limit = {w1[19:16], w0[15:0]}, attributes = {w1[23:20], w1[15:8]}, and sets valid to 1.
- R5: If index×8 + 7 is greater than the global limit, `fault` is high for exactly one cycle, one cycle after acceptance. No memory request is issued, and the selector and hidden cache stay unchanged.
- R6: A null selector (`sel[15:3]` = 0) loads without any fetch. One cycle after acceptance the selector holds the new value, the hidden base, limit and attributes are 0, and `ldt_valid` is 0.
- R7: `busy` rises one cycle after a fetching load is accepted and stays high until the commit edge. The hidden cache does not change until both words have arrived, and it is updated on the same edge at which `busy` falls.
- R8: Commands and task switches presented while `busy` is high are ignored.
- R9: When the unit is not busy, a task switch replaces the selector and every hidden field one cycle later, with valid set to 1. A command presented in the same cycle is dropped.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Operation code |
| cmd_base | input | 32 | Global base for a load global |
| cmd_limit | input | 16 | Global limit for a load global |
| cmd_sel | input | 16 | Selector for a load local |
| ts_valid | input | 1 | Task-switch load |
| ts_sel | input | 16 | Task-switch selector |
| ts_base | input | 32 | Task-switch base |
| ts_limit | input | 20 | Task-switch limit |
| ts_attr | input | 12 | Task-switch attributes |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_ready | input | 1 | Request accepted |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data word |
| busy | output | 1 | Fetch in progress |
| fault | output | 1 | Bounds fault pulse |
| st_valid | output | 1 | Store result present |
| st_base | output | 32 | Stored global base |
| st_limit | output | 16 | Stored global limit |
| st_sel | output | 16 | Stored local selector |
| ldt_base | output | 32 | Hidden local base |
| ldt_limit | output | 20 | Hidden local limit |
| ldt_attr | output | 12 | Hidden local attributes |
| ldt_valid | output | 1 | Hidden attributes valid |

## Verification
Store results, faults, null loads and task switches all appear one clock after the edge that accepts them. The bench drives stimulus on the falling edge and samples at the next falling edge. For a fetch, the first request address is checked at the falling edge after acceptance. The second address is checked at the falling edge after the first response. The committed cache is checked two falling edges after the second response, because one falling edge falls in `S_COMMIT` and is used to confirm that the old contents are still present. Selector indices are swept across and beyond the limit under two table configurations, and the request-ready and response latencies vary with the index.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int SEL_W  = 16;
    localparam int GLIM_W = 16;
    localparam int LLIM_W = 20;
    localparam int ATTR_W = 12;
    localparam int IDX_LSB = 3;

    typedef enum logic [1:0] {
        OP_LOAD_GLB  = 2'b00,
        OP_STORE_GLB = 2'b01,
        OP_LOAD_LOC  = 2'b10,
        OP_STORE_LOC = 2'b11
    } dtr_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR_LO,
        S_DATA_LO,
        S_ADDR_HI,
        S_DATA_HI,
        S_COMMIT
    } fetch_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LLIM_W-1:0] limit;
        logic [ATTR_W-1:0] attr;
        logic              valid;
    } ldt_cache_t;
endpackage

// File: rtl/dtr_sel_check.sv
module dtr_sel_check
    import dtr_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int AW = ADDR_W,
    parameter int LW = GLIM_W
) (
    input  logic [SW-1:0] sel,
    input  logic [AW-1:0] gdt_base,
    input  logic [LW-1:0] gdt_limit,
    output logic          is_null,
    output logic          beyond,
    output logic [AW-1:0] addr_lo,
    output logic [AW-1:0] addr_hi
);
    localparam int CW = (SW > LW ? SW : LW) + 1;
    localparam logic [SW-1:0] LOW_MASK = SW'((1 << IDX_LSB) - 1);

    logic [SW-1:0] offset;
    logic [CW-1:0] last_byte;

    always_comb begin
        offset    = sel & ~LOW_MASK;
        last_byte = CW'(sel | LOW_MASK);
        is_null   = (offset == '0);
        beyond    = last_byte > CW'(gdt_limit);
        addr_lo   = gdt_base + AW'(offset);
        addr_hi   = addr_lo + AW'(4);
    end
endmodule

// File: rtl/dtr_desc_unpack.sv
module dtr_desc_unpack
    import dtr_pkg::*;
(
    input  logic [WORD_W-1:0] word_lo,
    input  logic [WORD_W-1:0] word_hi,
    output ldt_cache_t        fields
);
    always_comb begin
        fields.base  = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
        fields.limit = {word_hi[19:16], word_lo[15:0]};
        fields.attr  = {word_hi[23:20], word_hi[15:8]};
        fields.valid = 1'b1;
    end
endmodule

// File: rtl/dtr_fetch_fsm.sv
module dtr_fetch_fsm
    import dtr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr_lo,
    input  logic [AW-1:0] start_addr_hi,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [WW-1:0] mem_rsp_data,
    output logic          busy,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    output logic [WW-1:0] word_lo,
    output logic [WW-1:0] word_hi,
    output logic          commit
);
    fetch_state_e state_q, state_d;
    logic [AW-1:0] addr_lo_q, addr_hi_q;
    logic          cap_lo, cap_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start)         state_d = S_ADDR_LO;
            S_ADDR_LO: if (mem_req_ready) state_d = S_DATA_LO;
            S_DATA_LO: if (mem_rsp_valid) state_d = S_ADDR_HI;
            S_ADDR_HI: if (mem_req_ready) state_d = S_DATA_HI;
            S_DATA_HI: if (mem_rsp_valid) state_d = S_COMMIT;
            S_COMMIT:                     state_d = S_IDLE;
            default:                      state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy          = 1'b1;
        mem_req_valid = 1'b0;
        mem_req_addr  = addr_lo_q;
        cap_lo        = 1'b0;
        cap_hi        = 1'b0;
        commit        = 1'b0;
        unique case (state_q)
            S_IDLE:    busy = 1'b0;
            S_ADDR_LO: mem_req_valid = 1'b1;
            S_DATA_LO: cap_lo = mem_rsp_valid;
            S_ADDR_HI: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = addr_hi_q;
            end
            S_DATA_HI: cap_hi = mem_rsp_valid;
            S_COMMIT:  commit = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            word_lo   <= '0;
            word_hi   <= '0;
        end else begin
            if (start && state_q == S_IDLE) begin
                addr_lo_q <= start_addr_lo;
                addr_hi_q <= start_addr_hi;
            end
            if (cap_lo) word_lo <= mem_rsp_data;
            if (cap_hi) word_hi <= mem_rsp_data;
        end
    end
endmodule

// File: rtl/dtr_unit.sv
module dtr_unit
    import dtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [GLIM_W-1:0] cmd_limit,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic              ts_valid,
    input  logic [SEL_W-1:0]  ts_sel,
    input  logic [ADDR_W-1:0] ts_base,
    input  logic [LLIM_W-1:0] ts_limit,
    input  logic [ATTR_W-1:0] ts_attr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              busy,
    output logic              fault,
    output logic              st_valid,
    output logic [ADDR_W-1:0] st_base,
    output logic [GLIM_W-1:0] st_limit,
    output logic [SEL_W-1:0]  st_sel,
    output logic [ADDR_W-1:0] ldt_base,
    output logic [LLIM_W-1:0] ldt_limit,
    output logic [ATTR_W-1:0] ldt_attr,
    output logic              ldt_valid
);
    localparam ldt_cache_t CACHE_RST = '{base: '0, limit: LLIM_W'(16'hFFFF), attr: '0, valid: 1'b0};

    logic [ADDR_W-1:0] gdt_base_q;
    logic [GLIM_W-1:0] gdt_limit_q;
    logic [SEL_W-1:0]  ldt_sel_q, pend_sel_q;
    ldt_cache_t        cache_q, fetched;

    logic              is_null, beyond, accept, ts_take, start, commit;
    logic [ADDR_W-1:0] addr_lo, addr_hi;
    logic [WORD_W-1:0] word_lo, word_hi;
    dtr_op_e           op;

    assign op      = dtr_op_e'(cmd_op);
    assign ts_take = ts_valid && !busy;
    assign accept  = cmd_valid && !busy && !ts_valid;
    assign start   = accept && op == OP_LOAD_LOC && !is_null && !beyond;

    dtr_sel_check u_check (
        .sel       (cmd_sel),
        .gdt_base  (gdt_base_q),
        .gdt_limit (gdt_limit_q),
        .is_null   (is_null),
        .beyond    (beyond),
        .addr_lo   (addr_lo),
        .addr_hi   (addr_hi)
    );

    dtr_fetch_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .start_addr_lo (addr_lo),
        .start_addr_hi (addr_hi),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .word_lo       (word_lo),
        .word_hi       (word_hi),
        .commit        (commit)
    );

    dtr_desc_unpack u_unpack (
        .word_lo (word_lo),
        .word_hi (word_hi),
        .fields  (fetched)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gdt_base_q  <= '0;
            gdt_limit_q <= '1;
            ldt_sel_q   <= '0;
            pend_sel_q  <= '0;
            cache_q     <= CACHE_RST;
            fault       <= 1'b0;
            st_valid    <= 1'b0;
            st_base     <= '0;
            st_limit    <= '0;
            st_sel      <= '0;
        end else begin
            fault    <= 1'b0;
            st_valid <= 1'b0;
            if (ts_take) begin
                ldt_sel_q <= ts_sel;
                cache_q   <= '{base: ts_base, limit: ts_limit, attr: ts_attr, valid: 1'b1};
            end else if (commit) begin
                ldt_sel_q <= pend_sel_q;
                cache_q   <= fetched;
            end else if (accept) begin
                unique case (op)
                    OP_LOAD_GLB: begin
                        gdt_base_q  <= cmd_base;
                        gdt_limit_q <= cmd_limit;
                    end
                    OP_STORE_GLB: begin
                        st_valid <= 1'b1;
                        st_base  <= gdt_base_q;
                        st_limit <= gdt_limit_q;
                        st_sel   <= '0;
                    end
                    OP_LOAD_LOC: begin
                        if (is_null) begin
                            ldt_sel_q <= cmd_sel;
                            cache_q   <= '0;
                        end else if (beyond) begin
                            fault <= 1'b1;
                        end else begin
                            pend_sel_q <= cmd_sel;
                        end
                    end
                    OP_STORE_LOC: begin
                        st_valid <= 1'b1;
                        st_base  <= '0;
                        st_limit <= '0;
                        st_sel   <= ldt_sel_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ldt_base  = cache_q.base;
    assign ldt_limit = cache_q.limit;
    assign ldt_attr  = cache_q.attr;
    assign ldt_valid = cache_q.valid;
endmodule

// File: rtl/dtr_unit_chk.sv
module dtr_unit_chk
    import dtr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              fault,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              st_valid,
    input logic [SEL_W-1:0]  st_sel,
    input logic [ADDR_W-1:0] st_base,
    input logic [GLIM_W-1:0] st_limit,
    input logic [ADDR_W-1:0] ldt_base,
    input logic [LLIM_W-1:0] ldt_limit,
    input logic [ATTR_W-1:0] ldt_attr,
    input logic              ldt_valid
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R7
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R5
    fault_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_req_valid && !busy);

    // R5
    fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $stable(ldt_base) && $stable(ldt_limit) && $stable(ldt_attr) && $stable(ldt_valid));

    // R3
    store_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_sel != '0 |-> st_base == '0 && st_limit == '0);

    // R7
    commit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ldt_valid);
endmodule

bind dtr_unit dtr_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .fault         (fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .st_valid      (st_valid),
    .st_sel        (st_sel),
    .st_base       (st_base),
    .st_limit      (st_limit),
    .ldt_base      (ldt_base),
    .ldt_limit     (ldt_limit),
    .ldt_attr      (ldt_attr),
    .ldt_valid     (ldt_valid)
);

// File: tb/dtr_unit_bench.sv
module dtr_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_limit = '0;
    logic [15:0] cmd_sel = '0;
    logic        ts_valid = 1'b0;
    logic [15:0] ts_sel = '0;
    logic [31:0] ts_base = '0;
    logic [19:0] ts_limit = '0;
    logic [11:0] ts_attr = '0;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        busy, fault, st_valid, ldt_valid;
    logic [31:0] st_base, ldt_base;
    logic [15:0] st_limit, st_sel;
    logic [19:0] ldt_limit;
    logic [11:0] ldt_attr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtr_unit u_dtr_unit (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a * 32'h9E3779B1 + 32'h1234_5678;
    endfunction

    task automatic send(input logic [1:0] op, input logic [31:0] b, input logic [15:0] l, input logic [15:0] s);
        cmd_valid = 1'b1; cmd_op = op; cmd_base = b; cmd_limit = l; cmd_sel = s;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic expect_global(input logic [31:0] b, input logic [15:0] l, input string tag);
        send(2'b01, '0, '0, '0);
        chk(st_valid && st_base == b && st_limit == l && st_sel == 0, tag, {st_base, st_limit, st_sel}, {b, l, 16'h0});
    endtask

    task automatic expect_local(input logic [15:0] s, input string tag);
        send(2'b11, '0, '0, '0);
        chk(st_valid && st_sel == s && st_base == 0 && st_limit == 0, tag, {st_base, st_limit, st_sel}, {32'h0, 16'h0, s});
    endtask

    task automatic fetch(input logic [31:0] gb, input logic [15:0] s, input int rdly, input int sdly, input bit poke);
        logic [31:0] alo, w0, w1, old_base;
        alo = gb + {16'h0, s & 16'hFFF8};
        w0 = mem_word(alo);
        w1 = mem_word(alo + 4);
        old_base = ldt_base;
        send(2'b10, '0, '0, s);
        chk(busy, "R7 busy after accept", busy, 1);
        chk(mem_req_valid && mem_req_addr == alo, "R4 first address", mem_req_addr, alo);
        if (poke) begin
            cmd_valid = 1'b1; cmd_op = 2'b00; cmd_base = 32'hDEAD_0000; cmd_limit = 16'h0001;
            ts_valid = 1'b1; ts_sel = 16'hABCD; ts_base = 32'h5555_5555; ts_limit = 20'h1; ts_attr = 12'h1;
            @(negedge clk);
            cmd_valid = 1'b0; ts_valid = 1'b0;
        end
        for (int i = 0; i < rdly; i++) begin
            @(negedge clk);
            chk(mem_req_valid && mem_req_addr == alo, "R10 held request", mem_req_addr, alo);
        end
        mem_req_ready = 1'b1; @(negedge clk); mem_req_ready = 1'b0;
        repeat (sdly) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = w0; @(negedge clk); mem_rsp_valid = 1'b0;
        chk(mem_req_valid && mem_req_addr == alo + 4, "R4 second address", mem_req_addr, alo + 4);
        chk(busy && ldt_base == old_base, "R7 no change after one word", ldt_base, old_base);
        mem_req_ready = 1'b1; @(negedge clk); mem_req_ready = 1'b0;
        repeat (sdly) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = w1; @(negedge clk); mem_rsp_valid = 1'b0;
        chk(busy && ldt_base == old_base, "R7 commit state holds old", ldt_base, old_base);
        @(negedge clk);
        chk(!busy, "R7 busy falls at commit", busy, 0);
        chk(ldt_base == {w1[31:24], w1[7:0], w0[31:16]}, "R4 base", ldt_base, {w1[31:24], w1[7:0], w0[31:16]});
        chk(ldt_limit == {w1[19:16], w0[15:0]}, "R4 limit", ldt_limit, {w1[19:16], w0[15:0]});
        chk(ldt_attr == {w1[23:20], w1[15:8]} && ldt_valid, "R4 attr/valid", {ldt_valid, ldt_attr}, {1'b1, w1[23:20], w1[15:8]});
        expect_local(s, "R4 selector");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] gbs [2];
        logic [15:0] gls [2];
        gbs[0] = 32'h0000_1000; gls[0] = 16'h003F;
        gbs[1] = 32'hFFFF_FFC0; gls[1] = 16'h0047;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !fault && !st_valid && !mem_req_valid, "R1 idle outputs", {busy, fault, st_valid}, 0);
        chk(ldt_base == 0 && ldt_limit == 20'h0FFFF && ldt_attr == 0 && !ldt_valid, "R1 hidden reset",
            {ldt_base, ldt_limit, ldt_attr}, {32'h0, 20'h0FFFF, 12'h0});
        expect_global(32'h0, 16'hFFFF, "R1 global reset");
        expect_local(16'h0, "R1 selector reset");

        for (int c = 0; c < 2; c++) begin
            send(2'b00, gbs[c], gls[c], '0);
            expect_global(gbs[c], gls[c], "R2 load/store global");
            for (int idx = 0; idx < 10; idx++) begin
                logic [15:0] s;
                logic [15:0] prev;
                s = {idx[12:0], idx[2:0]};
                send(2'b11, '0, '0, '0);
                prev = st_sel;
                if (idx == 0) begin
                    send(2'b10, '0, '0, s);
                    chk(!busy && !mem_req_valid, "R6 no fetch", busy, 0);
                    chk(ldt_base == 0 && ldt_limit == 0 && ldt_attr == 0 && !ldt_valid, "R6 null fields",
                        {ldt_valid, ldt_base, ldt_limit}, 0);
                    expect_local(s, "R6 null selector");
                end else if (idx * 8 + 7 > gls[c]) begin
                    logic [31:0] ob;
                    ob = ldt_base;
                    send(2'b10, '0, '0, s);
                    chk(fault && !mem_req_valid && !busy, "R5 fault pulse", {fault, mem_req_valid, busy}, 3'b100);
                    @(negedge clk);
                    chk(!fault && ldt_base == ob, "R5 pulse ends, cache kept", {fault, ldt_base}, {1'b0, ob});
                    expect_local(prev, "R5 selector kept");
                end else begin
                    fetch(gbs[c], s, idx % 3, (idx + 1) % 2, c == 0 && idx == 3);
                    if (c == 0 && idx == 3) begin
                        expect_global(gbs[c], gls[c], "R8 load global ignored while busy");
                    end
                end
            end
        end

        // R9 task switch with simultaneous command dropped
        ts_valid = 1'b1; ts_sel = 16'h0123; ts_base = 32'hCAFE_F00D; ts_limit = 20'hABCDE; ts_attr = 12'h9F2;
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_base = 32'h1; cmd_limit = 16'h1;
        @(negedge clk);
        ts_valid = 1'b0; cmd_valid = 1'b0;
        chk(ldt_base == 32'hCAFE_F00D && ldt_limit == 20'hABCDE && ldt_attr == 12'h9F2 && ldt_valid, "R9 task switch",
            {ldt_base, ldt_limit, ldt_attr}, {32'hCAFE_F00D, 20'hABCDE, 12'h9F2});
        expect_local(16'h0123, "R9 task selector");
        expect_global(gbs[1], gls[1], "R9 command dropped");
        expect_local(16'h0123, "R3 store local only selector");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule